// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits beside a true dual-port memory and settles clashes between its left and right ports. When both ports are enabled and present the same address, it lets one port through and raises an active-low busy toward the other. It also withholds that port's write strobe, so the losing write never reaches the array. Arbitration is first-come: a port that already held its address on the previous clock beats one that has just arrived. When both arrive on the same clock, the left port wins. The winner keeps the location for as long as the clash lasts.

A mode input selects master or slave. A master computes busy itself. A slave is used to widen the data word across several memories. It ignores its own address comparison and takes busy from a master's outputs. It blocks local writes while that busy is low and for one extra clock after it returns high, so a write never starts on an unsettled busy. All outputs are registered and change on the clock edge after the inputs that cause them.

Top module: `dp_contend_arb`

## Requirements
- R1: In master mode, busy is high on both ports after any edge where the two ports are not both enabled with equal addresses.
- R2: In master mode, when a clash starts and only one port was enabled at the same address on the previous clock, that port wins. After that edge the other port's busy is low.
- R3: The gated write of a port equals its enable AND its write strobe, registered. It is forced low on every cycle in which that port's busy output is low.
- R4: In master mode, the winner is held while the clash persists. Busy returns high on the edge after the addresses differ or either enable is low.
- R5: In master mode, when neither port or both ports held the address on the previous clock, the left port wins.
- R6: In slave mode, each busy output is the external busy input of that port, registered one clock. Address equality has no effect.
- R7: In slave mode, a port's gated write is low while its external busy input is low, and for one clock after it returns high.
- R8: In master mode, the external busy inputs have no effect on any output.
- R9: Busy is active low. Synchronous reset drives both busy outputs high and both gated writes low.
- R10: In master mode, the two busy outputs are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mst_mode | input | 1 | 1 = master (busy computed), 0 = slave (busy received) |
| l_en | input | 1 | Left port enable |
| l_addr | input | AW | Left port address |
| l_wr | input | 1 | Left port write strobe |
| r_en | input | 1 | Right port enable |
| r_addr | input | AW | Right port address |
| r_wr | input | 1 | Right port write strobe |
| l_busy_in_n | input | 1 | External busy for the left port (slave mode), active low |
| r_busy_in_n | input | 1 | External busy for the right port (slave mode), active low |
| l_busy_n | output | 1 | Busy toward the left port, active low |
| r_busy_n | output | 1 | Busy toward the right port, active low |
| l_wr_g | output | 1 | Gated left write enable to the array |
| r_wr_g | output | 1 | Gated right write enable to the array |

## Verification
Two functions can fall in one edge. The arbitration decision lowers a port's busy, and the write gating decides whether that same port's strobe reaches the array. The bench provokes this by presenting both ports' writes at one address on the clock the clash begins, both staggered and simultaneous. It judges that the loser's busy falls and its gated write stays low after that one edge, while the winner's write passes. In slave mode the same pairing is provoked by dropping an external busy during a write. The write must stay blocked for the extra settling clock.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  localparam int NPORT = 2;
  localparam int PL    = 0;
  localparam int PR    = 1;
endpackage

// File: rtl/dpa_match.sv
module dpa_match #(
  parameter int AW    = 14,
  parameter int NPORT = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NPORT-1:0]          en,
  input  logic [NPORT-1:0][AW-1:0]  addr,
  output logic                      match,
  output logic [NPORT-1:0]          stay
);
  logic [NPORT-1:0]         en_q;
  logic [NPORT-1:0][AW-1:0] addr_q;

  assign match = en[0] && en[1] && (addr[0] == addr[1]);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[p]   <= 1'b0;
        addr_q[p] <= '0;
      end else begin
        en_q[p]   <= en[p];
        addr_q[p] <= addr[p];
      end
    end
    // port was already sitting on this address last clock
    assign stay[p] = en_q[p] && en[p] && (addr_q[p] == addr[p]);
  end
endmodule

// File: rtl/dpa_owner.sv
module dpa_owner
  import dpa_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       mst,
  input  logic       match,
  input  logic [1:0] stay,
  output owner_e     own_q,
  output owner_e     own_nxt
);
  always_comb begin
    if (!mst || !match)
      own_nxt = OWN_NONE;
    else if (own_q != OWN_NONE)
      own_nxt = own_q;
    else if (stay[PR] && !stay[PL])
      own_nxt = OWN_RIGHT;
    else
      own_nxt = OWN_LEFT;
  end

  always_ff @(posedge clk) begin
    if (rst) own_q <= OWN_NONE;
    else     own_q <= own_nxt;
  end
endmodule

// File: rtl/dpa_slave_sync.sv
module dpa_slave_sync (
  input  logic clk,
  input  logic rst,
  input  logic bin_n,
  output logic settled
);
  logic bin_q;

  always_ff @(posedge clk) begin
    if (rst) bin_q <= 1'b1;
    else     bin_q <= bin_n;
  end

  // high now and high on the previous clock
  assign settled = bin_n && bin_q;
endmodule

// File: rtl/dp_contend_arb.sv
module dp_contend_arb
  import dpa_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mst_mode,
  input  logic          l_en,
  input  logic [AW-1:0] l_addr,
  input  logic          l_wr,
  input  logic          r_en,
  input  logic [AW-1:0] r_addr,
  input  logic          r_wr,
  input  logic          l_busy_in_n,
  input  logic          r_busy_in_n,
  output logic          l_busy_n,
  output logic          r_busy_n,
  output logic          l_wr_g,
  output logic          r_wr_g
);
  logic [NPORT-1:0]         en_v, wr_v, bin_v, busy_v, wrg_v, lose_v, ok_v;
  logic [NPORT-1:0][AW-1:0] addr_v;
  logic                     match;
  logic [NPORT-1:0]         stay;
  owner_e                   own_q, own_nxt;

  assign en_v   = {r_en, l_en};
  assign wr_v   = {r_wr, l_wr};
  assign bin_v  = {r_busy_in_n, l_busy_in_n};
  assign addr_v = {r_addr, l_addr};

  dpa_match #(.AW(AW), .NPORT(NPORT)) u_match (
    .clk(clk), .rst(rst), .en(en_v), .addr(addr_v),
    .match(match), .stay(stay)
  );

  dpa_owner u_owner (
    .clk(clk), .rst(rst), .mst(mst_mode), .match(match), .stay(stay),
    .own_q(own_q), .own_nxt(own_nxt)
  );

  assign lose_v[PL] = (own_nxt == OWN_RIGHT);
  assign lose_v[PR] = (own_nxt == OWN_LEFT);

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic busy_r, wrg_r;

    dpa_slave_sync u_sync (
      .clk(clk), .rst(rst), .bin_n(bin_v[p]), .settled(ok_v[p])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        busy_r <= 1'b1;
        wrg_r  <= 1'b0;
      end else if (mst_mode) begin
        busy_r <= !lose_v[p];
        wrg_r  <= en_v[p] && wr_v[p] && !lose_v[p];
      end else begin
        busy_r <= bin_v[p];
        wrg_r  <= en_v[p] && wr_v[p] && ok_v[p];
      end
    end

    assign busy_v[p] = busy_r;
    assign wrg_v[p]  = wrg_r;
  end

  assign l_busy_n = busy_v[PL];
  assign r_busy_n = busy_v[PR];
  assign l_wr_g   = wrg_v[PL];
  assign r_wr_g   = wrg_v[PR];
endmodule

// File: rtl/dpa_chk.sv
module dpa_chk #(
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst,
  input logic          mst_mode,
  input logic          l_en,
  input logic [AW-1:0] l_addr,
  input logic          r_en,
  input logic [AW-1:0] r_addr,
  input logic          l_busy_in_n,
  input logic          l_busy_n,
  input logic          r_busy_n,
  input logic          l_wr_g,
  input logic          r_wr_g
);
  logic clash;
  assign clash = l_en && r_en && (l_addr == r_addr);

  // R10
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    $past(mst_mode) |-> !(!l_busy_n && !r_busy_n));

  // R1
  nomatch_chk: assert property (@(posedge clk) disable iff (rst)
    (mst_mode && !clash) |=> (l_busy_n && r_busy_n));

  // R4
  hold_r_chk: assert property (@(posedge clk) disable iff (rst)
    (mst_mode && $past(mst_mode) && clash && !r_busy_n) |=> !r_busy_n);

  // R4
  hold_l_chk: assert property (@(posedge clk) disable iff (rst)
    (mst_mode && $past(mst_mode) && clash && !l_busy_n) |=> !l_busy_n);

  // R3
  lose_l_wr_chk: assert property (@(posedge clk) disable iff (rst)
    !l_busy_n |-> !l_wr_g);

  // R3
  lose_r_wr_chk: assert property (@(posedge clk) disable iff (rst)
    !r_busy_n |-> !r_wr_g);

  // R7
  slv_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (!mst_mode && !l_busy_in_n) |=> !l_wr_g);
endmodule

bind dp_contend_arb dpa_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .mst_mode(mst_mode),
  .l_en(l_en), .l_addr(l_addr), .r_en(r_en), .r_addr(r_addr),
  .l_busy_in_n(l_busy_in_n),
  .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
  .l_wr_g(l_wr_g), .r_wr_g(r_wr_g)
);

// File: tb/sim_dp_contend_arb.sv
module sim_dp_contend_arb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mst_mode = 1'b1;
  logic          l_en = 1'b0, r_en = 1'b0, l_wr = 1'b0, r_wr = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic          l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
  logic          l_busy_n, r_busy_n, l_wr_g, r_wr_g;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [3:0] expq[$];
  string      tagq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_contend_arb #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .mst_mode(mst_mode),
    .l_en(l_en), .l_addr(l_addr), .l_wr(l_wr),
    .r_en(r_en), .r_addr(r_addr), .r_wr(r_wr),
    .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
    .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
    .l_wr_g(l_wr_g), .r_wr_g(r_wr_g)
  );

  // driver: inputs at falling edge, expected outputs after next rising edge
  // expected order {l_busy_n, r_busy_n, l_wr_g, r_wr_g}
  task automatic step(input bit m, input bit le, input logic [AW-1:0] la, input bit lw,
                      input bit re, input logic [AW-1:0] ra, input bit rw,
                      input bit lbi, input bit rbi, input logic [3:0] exp, input string tag);
    @(negedge clk);
    mst_mode = m;
    l_en = le; l_addr = la; l_wr = lw;
    r_en = re; r_addr = ra; r_wr = rw;
    l_busy_in_n = lbi; r_busy_in_n = rbi;
    expq.push_back(exp);
    tagq.push_back(tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expq.size() > 0) begin
        logic [3:0] e, a;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        a = {l_busy_n, r_busy_n, l_wr_g, r_wr_g};
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s: got %b expected %b", t, a, e);
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if ({l_busy_n, r_busy_n, l_wr_g, r_wr_g} !== 4'b1100) begin
      errors++;
      $display("FAIL R9 reset: got %b expected 1100", {l_busy_n, r_busy_n, l_wr_g, r_wr_g});
    end
    rst = 1'b0;
    //    m  le la  lw re ra  rw lbi rbi exp
    step(1, 1, 5, 1, 0, 5, 1, 1, 1, 4'b1110, "R1 right disabled");
    step(1, 1, 5, 1, 1, 5, 1, 1, 1, 4'b1010, "R2/R3 left first wins");
    step(1, 1, 5, 1, 1, 5, 1, 1, 1, 4'b1010, "R4 hold left");
    step(1, 1, 6, 1, 1, 5, 1, 1, 1, 4'b1111, "R4 release on mismatch");
    step(1, 0, 0, 0, 0, 0, 0, 1, 1, 4'b1100, "R1 idle");
    step(1, 1, 9, 1, 1, 9, 1, 1, 1, 4'b1010, "R5 simultaneous tie");
    step(1, 0, 0, 0, 0, 0, 0, 1, 1, 4'b1100, "R4 release on disable");
    step(1, 0, 3, 0, 1, 3, 1, 1, 1, 4'b1101, "R1 right alone");
    step(1, 1, 3, 1, 1, 3, 1, 1, 1, 4'b0101, "R2/R3 right first wins");
    step(1, 1, 3, 1, 0, 3, 0, 1, 1, 4'b1110, "R4 right enable drops");
    step(1, 1, 7, 1, 0, 7, 1, 1, 1, 4'b1110, "R1 disabled port same addr");
    step(1, 1, 1, 1, 1, 2, 1, 1, 1, 4'b1111, "R1 distinct addresses");
    step(0, 1, 4, 1, 1, 4, 1, 1, 1, 4'b1111, "R6 slave ignores match");
    step(0, 1, 4, 1, 1, 4, 1, 0, 1, 4'b0101, "R6/R7 slave busy in low");
    step(0, 1, 4, 1, 1, 4, 1, 1, 1, 4'b1101, "R7 slave settling clock");
    step(0, 1, 4, 1, 1, 4, 1, 1, 1, 4'b1111, "R7 slave write resumes");
    step(1, 1, 4, 1, 1, 4, 1, 1, 0, 4'b1010, "R5/R8 both held, ext busy ignored");
    step(1, 1, 4, 0, 1, 4, 1, 0, 0, 4'b1000, "R3/R8 loser write blocked");
    step(1, 0, 4, 0, 1, 4, 1, 1, 1, 4'b1101, "R4 left disable releases");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule